// File: doc/BRIEF.md
# Shared Prescaler Timer and Watchdog

This block holds an 8-bit real-time counter and a free-running watchdog. One 8-bit prescaler serves both of them, and it is attached to one of the two at a time. The counter counts either the instruction-cycle tick or edges on an external pin. The pin passes through a two-flop synchroniser, and a mode bit chooses which edge counts. The watchdog counts ticks from its own slow clock, which is modelled here as an enable input. When its basic period ends it raises a one-cycle time-out. If the prescaler belongs to the watchdog, that period is first divided by the prescaler.

Software programs a 6-bit timer-mode register, which cannot be read back. It loads and reads the counter through a plain write port and a read bus. It services the watchdog with a clear strobe or a sleep strobe. The same prescale code gives a ratio one power of two lower when the watchdog owns the prescaler than when the counter owns it.

Top module: `ptw_timer_wdog`

## Requirements
- R1: After reset the counter reads 0 and `wdt_timeout` is low. The mode register holds 6'b111111: pin source, falling edge, prescaler on the watchdog, code 7.
- R2: Mode bit layout: bits [2:0] hold the prescale code. Bit 3 gives the prescaler to the watchdog (1) or to the counter (0). Bit 4 selects the falling (1) or rising (0) pin edge. Bit 5 selects the pin (1) or the instruction tick (0) as the counter source. A write takes effect from the next cycle.
- R3: With bit 5 = 0 and the prescaler on the watchdog, the counter advances by one on every cycle in which `icyc_en` is high.
- R4: With the prescaler on the counter, the counter advances once per 2^(code+1) source events (1:2 up to 1:256).
- R5: With bit 5 = 1, a pin transition of the selected polarity raises the count on `cnt_rdata` after the third rising clock edge following the transition. Transitions of the other polarity leave the counter unchanged.
- R6: The counter wraps from 8'hFF to 8'h00.
- R7: `cnt_we` loads `cnt_wdata` at the next edge and takes priority over an increment in the same cycle. When the counter owns the prescaler, the write also clears it.
- R8: With `wdt_on` high, the watchdog's basic period is 2^WDT_W ticks of `wdt_tick`. With the prescaler on the watchdog, a time-out occurs once per 2^code basic periods (1:1 up to 1:128).
- R9: With the prescaler on the counter, a time-out occurs at the end of every basic period, with no division.
- R10: `wdt_clr` or `sleep_req` clears the watchdog count. When the watchdog owns the prescaler, either strobe also clears the prescaler.
- R11: With `wdt_on` low the watchdog stays at zero and `wdt_timeout` never rises.
- R12: `wdt_timeout` is high for exactly one cycle: the cycle after the edge at which the tick completing the period is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| icyc_en | input | 1 | Instruction-cycle tick, counter source when bit 5 = 0 |
| wdt_tick | input | 1 | Watchdog oscillator tick |
| wdt_on | input | 1 | Watchdog enable option |
| ext_pin | input | 1 | Asynchronous external count pin |
| mode_we | input | 1 | Timer-mode register write strobe |
| mode_wdata | input | 6 | Timer-mode write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep strobe, also clears the watchdog |
| cnt_rdata | output | CNT_W | Current counter value |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The assertions rely on three things: `rst_n` is released synchronously, every strobe is sampled only at rising edges, and WDT_W is at least 2. The last condition prevents two basic periods from ending on consecutive edges. The bench drives every input on the falling clock edge, so each strobe is seen as a clean single-cycle level. It leaves `ext_pin` free to change on any cycle, because the synchroniser absorbs it. A final phase randomises all inputs together, including mode writes and `wdt_on`, and compares every cycle against a behavioural model.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Prescale code width; the prescaler is 2**PS_CODE_W bits wide.
  localparam int PS_CODE_W = 3;
  localparam int PS_W      = 1 << PS_CODE_W;
  localparam int MODE_W    = PS_CODE_W + 3;

  // Packed so that the write data maps bit for bit (MSB first).
  typedef struct packed {
    logic                 src_pin;    // bit 5: 1 = external pin, 0 = instruction tick
    logic                 fall_edge;  // bit 4: 1 = falling pin edge counts
    logic                 ps_to_wdt;  // bit 3: 1 = prescaler on watchdog
    logic [PS_CODE_W-1:0] ps_code;    // bits 2..0: prescale code
  } tmode_t;

  localparam tmode_t TMODE_RST = '{src_pin: 1'b1, fall_edge: 1'b1,
                                   ps_to_wdt: 1'b1, ps_code: '1};

endpackage

// File: rtl/ptw_pin_sync.sv
module ptw_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);

  // chain_q[0..SYNC_STAGES-1] synchronise, chain_q[SYNC_STAGES] holds the previous sample
  logic [SYNC_STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], pin_async};
    rise    =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    fall    = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

endmodule

// File: rtl/ptw_prescaler.sv
module ptw_prescaler #(
  parameter int PS_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       in_evt,
  input  logic [$clog2(PS_W+1)-1:0]  log2_ratio,
  output logic                       out_evt
);

  logic [PS_W-1:0] ps_q, ps_d, low_mask;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (i < int'(log2_ratio)) low_mask[i] = 1'b1;
    end
    out_evt = in_evt && !clr && ((ps_q & low_mask) == low_mask);
    ps_d    = ps_q;
    if (clr)         ps_d = '0;
    else if (in_evt) ps_d = ps_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end

  // R10 / R7: a clear leaves the prescaler at zero
  p_ps_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ps_q == '0));

endmodule

// File: rtl/ptw_wdog.sv
module ptw_wdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic base_evt
);

  logic [WDT_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    base_evt = run && !clr && tick && (wcnt_q == '1);
    wcnt_d   = wcnt_q;
    if (!run || clr) wcnt_d = '0;
    else if (tick)   wcnt_d = wcnt_q + WDT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  p_wdt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wcnt_q == '0));

  p_wdt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (wcnt_q == '0));

endmodule

// File: rtl/ptw_timer_wdog.sv
module ptw_timer_wdog
  import ptw_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icyc_en,
  input  logic              wdt_tick,
  input  logic              wdt_on,
  input  logic              ext_pin,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              wdt_clr,
  input  logic              sleep_req,
  output logic [CNT_W-1:0]  cnt_rdata,
  output logic              wdt_timeout
);

  localparam int SEL_W = $clog2(PS_W + 1);

  tmode_t            mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              to_q, to_d;

  logic              pin_rise, pin_fall, src_evt;
  logic              base_evt, wd_clear;
  logic              ps_in, ps_clr, ps_out, cnt_inc;
  logic [SEL_W-1:0]  ps_sel;

  ptw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .rise      (pin_rise),
    .fall      (pin_fall)
  );

  ptw_wdog #(.WDT_W(WDT_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wdt_on),
    .clr      (wd_clear),
    .tick     (wdt_tick),
    .base_evt (base_evt)
  );

  ptw_prescaler #(.PS_W(PS_W)) u_ps (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ps_clr),
    .in_evt     (ps_in),
    .log2_ratio (ps_sel),
    .out_evt    (ps_out)
  );

  // Routing of the shared prescaler
  always_comb begin
    wd_clear = wdt_clr | sleep_req;
    src_evt  = mode_q.src_pin ? (mode_q.fall_edge ? pin_fall : pin_rise) : icyc_en;
    if (mode_q.ps_to_wdt) begin
      ps_sel  = SEL_W'(mode_q.ps_code);
      ps_in   = base_evt;
      ps_clr  = wd_clear;
      cnt_inc = src_evt;
      to_d    = ps_out;
    end else begin
      ps_sel  = SEL_W'(mode_q.ps_code) + SEL_W'(1);
      ps_in   = src_evt;
      ps_clr  = cnt_we;
      cnt_inc = ps_out;
      to_d    = base_evt;
    end
  end

  // Next state of mode and counter
  always_comb begin
    mode_d = mode_we ? tmode_t'(mode_wdata) : mode_q;
    cnt_d  = cnt_q;
    if (cnt_we)       cnt_d = cnt_wdata;
    else if (cnt_inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TMODE_RST;
      cnt_q  <= '0;
      to_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      to_q   <= to_d;
    end
  end

  assign cnt_rdata   = cnt_q;
  assign wdt_timeout = to_q;

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_cnt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  p_to_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  p_to_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_on |=> !wdt_timeout);

endmodule

// File: tb/tb_ptw_timer_wdog.sv
`timescale 1ns/1ps
module tb_ptw_timer_wdog;

  localparam int WDT_W = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       icyc_en, wdt_tick, wdt_on, ext_pin, mode_we, cnt_we, wdt_clr, sleep_req;
  logic [5:0] mode_wdata;
  logic [7:0] cnt_wdata, cnt_rdata;
  logic       wdt_timeout;

  int    n_vec  = 0;
  int    n_fail = 0;
  int    n_to   = 0;
  int    last_to = 0;
  string cur_req = "R1";

  ptw_timer_wdog #(.CNT_W(8), .WDT_W(WDT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en), .wdt_tick(wdt_tick), .wdt_on(wdt_on),
    .ext_pin(ext_pin), .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .wdt_clr(wdt_clr), .sleep_req(sleep_req),
    .cnt_rdata(cnt_rdata), .wdt_timeout(wdt_timeout)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int m_mode, m_cnt, m_ps, m_wdt, m_to;
  bit m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 63; m_cnt = 0; m_ps = 0; m_wdt = 0; m_to = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit src, base, psout, clr_w, to_w;
      int code, ratio, wmax;
      code  = m_mode % 8;
      to_w  = ((m_mode / 8) % 2) == 1;
      if ((m_mode / 32) % 2 == 1)
        src = ((m_mode / 16) % 2 == 1) ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
      else
        src = icyc_en;
      wmax  = (1 << WDT_W) - 1;
      clr_w = wdt_clr || sleep_req;
      base  = wdt_on && !clr_w && wdt_tick && (m_wdt == wmax);
      ratio = to_w ? (1 << code) : (1 << (code + 1));
      psout = 0;
      if (to_w ? clr_w : cnt_we) m_ps = 0;
      else if (to_w ? base : src) begin
        psout = ((m_ps + 1) % ratio) == 0;
        m_ps  = (m_ps + 1) % 256;
      end
      if (cnt_we) m_cnt = cnt_wdata;
      else if (to_w ? src : psout) m_cnt = (m_cnt + 1) % 256;
      m_to = (to_w ? psout : base) ? 1 : 0;
      if (!wdt_on || clr_w) m_wdt = 0;
      else if (wdt_tick)    m_wdt = (m_wdt + 1) % (wmax + 1);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      if (mode_we) m_mode = mode_wdata;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: compare at the falling edge, then drive the next inputs
  task automatic cyc(input bit ic = 0, input bit wt = 0, input bit pin = 0,
                     input bit clr = 0, input bit slp = 0,
                     input bit mwe = 0, input int mval = 0,
                     input bit cwe = 0, input int cval = 0);
    @(negedge clk);
    if (rst_n) begin
      chk({cur_req, " cnt"}, int'(cnt_rdata), m_cnt);
      chk({cur_req, " timeout"}, int'(wdt_timeout), m_to);
      if (wdt_timeout) begin
        n_to++;
        if (last_to) chk("R12 pulse width", 2, 1);
      end
      last_to = int'(wdt_timeout);
    end
    icyc_en = ic; wdt_tick = wt; ext_pin = pin; wdt_clr = clr; sleep_req = slp;
    mode_we = mwe; mode_wdata = 6'(mval); cnt_we = cwe; cnt_wdata = 8'(cval);
  endtask

  task automatic pin_pulses(input int n, input bit idle_level);
    for (int i = 0; i < n; i++) begin
      cyc(.pin(!idle_level)); cyc(.pin(!idle_level));
      cyc(.pin(idle_level));  cyc(.pin(idle_level));
    end
    for (int i = 0; i < 4; i++) cyc(.pin(idle_level));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wdt_on = 1'b0;
    icyc_en = 0; wdt_tick = 0; ext_pin = 0; wdt_clr = 0; sleep_req = 0;
    mode_we = 0; mode_wdata = 0; cnt_we = 0; cnt_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    cyc(); chk("R1 cnt after reset", int'(cnt_rdata), 0);
    chk("R1 timeout after reset", int'(wdt_timeout), 0);

    // R2/R3: internal tick, prescaler on watchdog (mode 001000)
    cur_req = "R3";
    cyc(.mwe(1), .mval(6'b001000));
    for (int i = 0; i < 10; i++) cyc(.ic(1));
    cyc(); chk("R3 ten ticks", int'(cnt_rdata), 10);
    for (int i = 0; i < 6; i++) cyc(.ic(i % 2));
    cyc(); chk("R2 R3 sparse ticks", int'(cnt_rdata), 13);

    // R4: prescaler on counter, code 2 -> 1:8
    cur_req = "R4";
    cyc(.mwe(1), .mval(6'b000010));
    cyc(.cwe(1), .cval(0));
    for (int i = 0; i < 24; i++) cyc(.ic(1));
    cyc(); chk("R4 1:8 after 24", int'(cnt_rdata), 3);
    cyc(.mwe(1), .mval(6'b000000));
    cyc(.cwe(1), .cval(0));
    for (int i = 0; i < 9; i++) cyc(.ic(1));
    cyc(); chk("R4 1:2 after 9", int'(cnt_rdata), 4);

    // R5: pin rising edges, latency of three edges
    cur_req = "R5";
    cyc(.mwe(1), .mval(6'b101000));
    cyc(.cwe(1), .cval(0));
    cyc(.pin(1)); cyc(.pin(1)); cyc(.pin(1));
    chk("R5 no count after two edges", int'(cnt_rdata), 0);
    cyc(.pin(1));
    chk("R5 count after third edge", int'(cnt_rdata), 1);
    cyc(.pin(0)); cyc(.pin(0)); cyc(.pin(0)); cyc(.pin(0));
    chk("R5 falling ignored in rising mode", int'(cnt_rdata), 1);
    pin_pulses(4, 1'b0);
    chk("R5 rising pulses", int'(cnt_rdata), 5);
    // falling edge mode
    cyc(.mwe(1), .mval(6'b111000));
    cyc(.pin(1)); cyc(.pin(1)); cyc(.pin(1)); cyc(.pin(1));
    chk("R5 rising ignored in falling mode", int'(cnt_rdata), 5);
    pin_pulses(3, 1'b1);
    chk("R5 falling pulses", int'(cnt_rdata), 8);

    // R6: wrap
    cur_req = "R6";
    cyc(.mwe(1), .mval(6'b001000));
    cyc(.cwe(1), .cval(8'hFE));
    cyc(.ic(1)); cyc(.ic(1)); cyc(.ic(1));
    cyc(); chk("R6 wrap FE+3", int'(cnt_rdata), 1);

    // R7: write clears counter-owned prescaler, load beats increment
    cur_req = "R7";
    cyc(.mwe(1), .mval(6'b000011));
    cyc(.cwe(1), .cval(0));
    for (int i = 0; i < 10; i++) cyc(.ic(1));
    cyc(.ic(1), .cwe(1), .cval(5));
    cyc(); chk("R7 load wins", int'(cnt_rdata), 5);
    for (int i = 0; i < 15; i++) cyc(.ic(1));
    cyc(); chk("R7 prescaler cleared", int'(cnt_rdata), 5);
    cyc(.ic(1));
    cyc(); chk("R7 sixteenth event", int'(cnt_rdata), 6);

    // R8: watchdog with prescaler 1:2, basic period 8
    cur_req = "R8";
    wdt_on = 1'b1;
    cyc(.mwe(1), .mval(6'b001001));
    cyc(.clr(1));
    n_to = 0;
    for (int i = 0; i < 64; i++) cyc(.wt(1));
    cyc(); chk("R8 timeouts in 64 ticks", n_to, 4);

    // R9: prescaler on counter, no division
    cur_req = "R9";
    cyc(.mwe(1), .mval(6'b000111));
    cyc(.clr(1));
    n_to = 0;
    for (int i = 0; i < 32; i++) cyc(.wt(1));
    cyc(); chk("R9 timeouts in 32 ticks", n_to, 4);

    // R10: clear and sleep strobes keep the watchdog from expiring
    cur_req = "R10";
    cyc(.mwe(1), .mval(6'b001000));
    cyc(.clr(1));
    n_to = 0;
    for (int i = 0; i < 60; i++) begin
      if (i % 6 == 5) cyc(.clr(i % 12 == 5), .slp(i % 12 == 11));
      else            cyc(.wt(1));
    end
    cyc(); chk("R10 no timeout with service", n_to, 0);

    // R11: disabled watchdog
    cur_req = "R11";
    wdt_on = 1'b0;
    n_to = 0;
    for (int i = 0; i < 100; i++) cyc(.wt(1));
    cyc(); chk("R11 no timeout when off", n_to, 0);

    // R2/R12: everything random, compared cycle by cycle
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) wdt_on = 1'($urandom_range(0, 3) != 0);
      cyc(.ic(1'($urandom_range(0, 1))), .wt(1'($urandom_range(0, 3) != 0)),
          .pin(1'($urandom_range(0, 1))), .clr(($urandom_range(0, 199) == 0)),
          .slp(($urandom_range(0, 299) == 0)), .mwe(($urandom_range(0, 149) == 0)),
          .mval(int'($urandom_range(0, 63))), .cwe(($urandom_range(0, 99) == 0)),
          .cval(int'($urandom_range(0, 255))));
    end
    cyc();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule